// File: doc/BRIEF.md
# Two-Step Single-Slope Conversion Sequencer

This block sequences a column-parallel, two-step single-slope conversion for one line of pixels. One comparator sits in each column, and all columns share two global ramps. A start pulse opens a one-cycle sample window in which the addressed pixel row is selected. The block then runs a coarse phase. In this phase a 5-bit counter walks a 32-level coarse reference, and every column records the counter value at the first rising edge of its comparator.

After a single settling cycle, a 7-bit counter drives a binary-weighted fine ramp, and each column records the fine value at its comparator's first rise. The coarse code of each column also steers that column's reference-switch select for the fine phase. A column whose comparator never rises keeps the top code of that phase.

Each column's 12-bit result is the coarse code followed by the fine code. Once the one-cycle completion flag has been seen, any column can be read through a column address. The comparators, ramps and pixels sit outside the block. Here they appear as a digital comparator vector and as counter and select outputs.

Top module: `tss_adc_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `sample_en`, `coarse_active` and `fine_active` are 0, `row_sel` is all zero, and `rd_data` is 0 for every column address.
- R2: A start seen in the idle state produces this sequence. First, one sample cycle. Then 32 coarse cycles with `coarse_code` running 0 to 31. Then one settling cycle in which only `busy` is high. Then 128 fine cycles with `fine_code` running 0 to 127. Then `done`, counted 162 clock edges after the edge that sampled start.
- R3: `done` is high for exactly one cycle. On the following cycle `busy` is 0.
- R4: A start asserted while a conversion is running has no effect on the phase sequence or its timing.
- R5: In the coarse phase, a column stores the `coarse_code` value shown in the cycle in which its comparator first goes from low to high.
- R6: Later rising edges of a column's comparator within the same phase leave that column's stored code unchanged.
- R7: A column whose comparator never rises in a phase stores the maximum code of that phase: 31 for coarse, 127 for fine.
- R8: The result of a column is {coarse[4:0], fine[6:0]}. `rd_data` shows the result of the column selected by `rd_col` in the same cycle, without a register.
- R9: Column i's reference select, bits [5i+4:5i] of `ref_sel`, equals that column's stored coarse code from the settling cycle through `done`. It does not change during the fine phase.
- R10: `row_sel` is the one-hot decode of `row_addr` (bit `row_addr` set) during the sample cycle, and all zero in every other cycle.
- R11: A comparator that is already high when a phase begins counts as rising in the first cycle of that phase, and stores code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a conversion when idle |
| cmp | input | 64 | Comparator output per column |
| row_addr | input | 6 | Pixel row to convert |
| rd_col | input | 6 | Column whose result appears on `rd_data` |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion flag |
| sample_en | output | 1 | Sample window |
| coarse_active | output | 1 | Coarse phase running |
| fine_active | output | 1 | Fine phase running |
| coarse_code | output | 5 | Coarse ramp step |
| fine_code | output | 7 | Fine ramp step |
| ref_sel | output | 320 | Per-column reference select, 5 bits per column |
| row_sel | output | 64 | One-hot row select during sampling |
| rd_data | output | 12 | Result of column `rd_col` |

## Verification
Each phase output and ramp code is due a fixed number of edges after the start edge. The sample window comes at edge 0, coarse step k at edge k+1, the settling cycle at edge 33, fine step k at edge k+34 and `done` at edge 162. The bench counts edges from the start edge and compares every cycle one time unit after the edge. The comparator model is combinational on the ramp codes, so a column that crosses at code t is latched at the following edge. Its stored value is therefore due from the next cycle onward. Results and reference selects are checked in the settling cycle and after `done`. `rd_data` is combinational, so readout is compared one time unit after `rd_col` changes.

// File: rtl/tss_pkg.sv
// Shared types for the two-step single-slope sequencer.
// Assumes: a single clock domain; all state is reset synchronously.
package tss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_COARSE,
        ST_HOLD,
        ST_FINE,
        ST_DONE
    } tss_state_e;
endpackage

// File: rtl/tss_seq.sv
// Phase sequencer: the state machine plus the coarse and fine ramp counters.
// Assumes: start is a level sampled only in IDLE; each counter runs from 0 up
// to its all-ones value and then holds until it is restarted.
module tss_seq
    import tss_pkg::*;
#(
    parameter int COARSE_BITS = 5,
    parameter int FINE_BITS   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output tss_state_e             state,
    output logic [COARSE_BITS-1:0] ccnt,
    output logic [FINE_BITS-1:0]   fcnt
);
    localparam logic [COARSE_BITS-1:0] CMAX = '1;
    localparam logic [FINE_BITS-1:0]   FMAX = '1;

    // State register and ramp counters advance together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ccnt  <= '0;
            fcnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) state <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    state <= ST_COARSE;
                    ccnt  <= '0;
                end
                ST_COARSE: begin
                    if (ccnt == CMAX) state <= ST_HOLD;
                    else              ccnt  <= ccnt + 1'b1;
                end
                ST_HOLD: begin
                    state <= ST_FINE;
                    fcnt  <= '0;
                end
                ST_FINE: begin
                    if (fcnt == FMAX) state <= ST_DONE;
                    else              fcnt  <= fcnt + 1'b1;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tss_col_latch.sv
// Per-column capture: stores the ramp code at the first comparator rise of
// each phase. Each code is preset to its maximum when its phase is armed, so
// a column that never rises keeps the maximum.
// Assumes: arm_c comes one cycle before the coarse phase and arm_f one cycle
// before the fine phase; comparator history is cleared outside the phases.
module tss_col_latch #(
    parameter int COARSE_BITS = 5,
    parameter int FINE_BITS   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm_c,
    input  logic                   arm_f,
    input  logic                   act_c,
    input  logic                   act_f,
    input  logic                   cmp,
    input  logic [COARSE_BITS-1:0] ccnt,
    input  logic [FINE_BITS-1:0]   fcnt,
    output logic [COARSE_BITS-1:0] c_code,
    output logic [FINE_BITS-1:0]   f_code
);
    logic cmp_q;
    logic got_c;
    logic got_f;
    logic rise;

    // A rise is the comparator high now while it was low (or not yet in a phase) before.
    assign rise = cmp && !cmp_q;

    // Comparator history, held at zero outside both phases.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= (act_c || act_f) ? cmp : 1'b0;
    end

    // Coarse capture, once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_code <= '0;
            got_c  <= 1'b0;
        end else if (arm_c) begin
            c_code <= '1;
            got_c  <= 1'b0;
        end else if (act_c && rise && !got_c) begin
            c_code <= ccnt;
            got_c  <= 1'b1;
        end
    end

    // Fine capture, once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_code <= '0;
            got_f  <= 1'b0;
        end else if (arm_f) begin
            f_code <= '1;
            got_f  <= 1'b0;
        end else if (act_f && rise && !got_f) begin
            f_code <= fcnt;
            got_f  <= 1'b1;
        end
    end
endmodule

// File: rtl/tss_readout.sv
// Readout and row selection: picks one column's result by address and decodes
// the row address into a one-hot select that is live only while sampling.
// Assumes: addresses beyond the column count read as zero.
module tss_readout #(
    parameter int NUM_COLS    = 64,
    parameter int NUM_ROWS    = 64,
    parameter int COARSE_BITS = 5,
    parameter int FINE_BITS   = 7,
    localparam int COL_W      = $clog2(NUM_COLS),
    localparam int ROW_W      = $clog2(NUM_ROWS),
    localparam int RES_W      = COARSE_BITS + FINE_BITS
) (
    input  logic [NUM_COLS*COARSE_BITS-1:0] c_bus,
    input  logic [NUM_COLS*FINE_BITS-1:0]   f_bus,
    input  logic [COL_W-1:0]                rd_col,
    input  logic [ROW_W-1:0]                row_addr,
    input  logic                            sample_en,
    output logic [RES_W-1:0]                rd_data,
    output logic [NUM_ROWS-1:0]             row_sel
);
    logic [RES_W-1:0] res [NUM_COLS];

    // Unpack each column's result as {coarse, fine}.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_res
        assign res[c] = {c_bus[c*COARSE_BITS +: COARSE_BITS], f_bus[c*FINE_BITS +: FINE_BITS]};
    end

    // Column multiplexer for the read port.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (rd_col == COL_W'(c)) rd_data = res[c];
        end
    end

    // Row decode, gated by the sample window.
    always_comb begin
        row_sel = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (sample_en && row_addr == ROW_W'(r)) row_sel[r] = 1'b1;
        end
    end
endmodule

// File: rtl/tss_adc_ctrl.sv
// Top of the two-step single-slope conversion sequencer. Runs the sample,
// coarse, settle and fine phases over every column in parallel, steers each
// column's reference select from its coarse code, and serves results by column
// address.
// Assumes: comparator inputs are synchronous to clk and respond to the codes
// shown on coarse_code/fine_code during the active phase.
module tss_adc_ctrl
    import tss_pkg::*;
#(
    parameter int NUM_COLS    = 64,
    parameter int NUM_ROWS    = 64,
    parameter int COARSE_BITS = 5,
    parameter int FINE_BITS   = 7,
    localparam int COL_W      = $clog2(NUM_COLS),
    localparam int ROW_W      = $clog2(NUM_ROWS),
    localparam int RES_W      = COARSE_BITS + FINE_BITS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [NUM_COLS-1:0]             cmp,
    input  logic [ROW_W-1:0]                row_addr,
    input  logic [COL_W-1:0]                rd_col,
    output logic                            busy,
    output logic                            done,
    output logic                            sample_en,
    output logic                            coarse_active,
    output logic                            fine_active,
    output logic [COARSE_BITS-1:0]          coarse_code,
    output logic [FINE_BITS-1:0]            fine_code,
    output logic [NUM_COLS*COARSE_BITS-1:0] ref_sel,
    output logic [NUM_ROWS-1:0]             row_sel,
    output logic [RES_W-1:0]                rd_data
);
    tss_state_e                      state;
    logic [NUM_COLS*COARSE_BITS-1:0] c_bus;
    logic [NUM_COLS*FINE_BITS-1:0]   f_bus;

    tss_seq #(
        .COARSE_BITS (COARSE_BITS),
        .FINE_BITS   (FINE_BITS)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .ccnt  (coarse_code),
        .fcnt  (fine_code)
    );

    // Phase flags decoded from the state.
    assign busy          = (state != ST_IDLE);
    assign done          = (state == ST_DONE);
    assign sample_en     = (state == ST_SAMPLE);
    assign coarse_active = (state == ST_COARSE);
    assign fine_active   = (state == ST_FINE);

    // One capture slice per column.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        tss_col_latch #(
            .COARSE_BITS (COARSE_BITS),
            .FINE_BITS   (FINE_BITS)
        ) u_col (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_c  (state == ST_SAMPLE),
            .arm_f  (state == ST_HOLD),
            .act_c  (state == ST_COARSE),
            .act_f  (state == ST_FINE),
            .cmp    (cmp[c]),
            .ccnt   (coarse_code),
            .fcnt   (fine_code),
            .c_code (c_bus[c*COARSE_BITS +: COARSE_BITS]),
            .f_code (f_bus[c*FINE_BITS +: FINE_BITS])
        );
    end

    // Coarse codes steer each column's reference switches.
    assign ref_sel = c_bus;

    tss_readout #(
        .NUM_COLS    (NUM_COLS),
        .NUM_ROWS    (NUM_ROWS),
        .COARSE_BITS (COARSE_BITS),
        .FINE_BITS   (FINE_BITS)
    ) u_rd (
        .c_bus     (c_bus),
        .f_bus     (f_bus),
        .rd_col    (rd_col),
        .row_addr  (row_addr),
        .sample_en (sample_en),
        .rd_data   (rd_data),
        .row_sel   (row_sel)
    );
endmodule

// File: rtl/tss_adc_ctrl_chk.sv
// Protocol checker for tss_adc_ctrl, attached by bind. Watches only the ports.
module tss_adc_ctrl_chk #(
    parameter int NUM_COLS    = 64,
    parameter int NUM_ROWS    = 64,
    parameter int COARSE_BITS = 5,
    parameter int FINE_BITS   = 7
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            start,
    input logic                            busy,
    input logic                            done,
    input logic                            sample_en,
    input logic                            coarse_active,
    input logic                            fine_active,
    input logic [COARSE_BITS-1:0]          coarse_code,
    input logic [FINE_BITS-1:0]            fine_code,
    input logic [NUM_COLS*COARSE_BITS-1:0] ref_sel,
    input logic [NUM_ROWS-1:0]             row_sel
);
    // R3: completion lasts one cycle and returns to idle.
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2: the coarse ramp climbs by one each coarse cycle.
    a_r2_coarse_step: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_active && $past(coarse_active)) |-> (coarse_code == COARSE_BITS'($past(coarse_code) + 1'b1)));

    // R2: the fine ramp climbs by one each fine cycle.
    a_r2_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_active && $past(fine_active)) |-> (fine_code == FINE_BITS'($past(fine_code) + 1'b1)));

    // R2: one settling cycle separates the phases, and the fine ramp starts at 0.
    a_r2_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coarse_active) |-> (busy && !fine_active));
    a_r2_fine_begin: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coarse_active) |=> (fine_active && fine_code == '0));

    // R4: a start during a conversion does not reopen sampling.
    a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> (busy && !sample_en));

    // R9: reference selects hold during the fine phase.
    a_r9_ref_stable: assert property (@(posedge clk) disable iff (!rst_n)
        fine_active |-> $stable(ref_sel));

    // R10: the row select is one-hot in the sample window and empty elsewhere.
    a_r10_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> ($countones(row_sel) == 1));
    a_r10_row_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |-> (row_sel == '0));
endmodule

bind tss_adc_ctrl tss_adc_ctrl_chk #(
    .NUM_COLS    (NUM_COLS),
    .NUM_ROWS    (NUM_ROWS),
    .COARSE_BITS (COARSE_BITS),
    .FINE_BITS   (FINE_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .sample_en     (sample_en),
    .coarse_active (coarse_active),
    .fine_active   (fine_active),
    .coarse_code   (coarse_code),
    .fine_code     (fine_code),
    .ref_sel       (ref_sel),
    .row_sel       (row_sel)
);

// File: tb/tb_tss_adc_ctrl.sv
// Bench for tss_adc_ctrl: runs conversions with computed comparator crossing
// points and sweeps every column on readout.
module tb_tss_adc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 64;
    localparam int NR = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NC-1:0]     cmp;
    logic [5:0]        row_addr = '0;
    logic [5:0]        rd_col = '0;
    logic              busy, done, sample_en, coarse_active, fine_active;
    logic [4:0]        coarse_code;
    logic [6:0]        fine_code;
    logic [NC*5-1:0]   ref_sel;
    logic [NR-1:0]     row_sel;
    logic [11:0]       rd_data;

    int  tc [NC];
    int  tf [NC];
    bit  glitch = 1'b0;
    int  n_checks = 0;
    int  n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tss_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp),
        .row_addr(row_addr), .rd_col(rd_col), .busy(busy), .done(done),
        .sample_en(sample_en), .coarse_active(coarse_active),
        .fine_active(fine_active), .coarse_code(coarse_code),
        .fine_code(fine_code), .ref_sel(ref_sel), .row_sel(row_sel),
        .rd_data(rd_data)
    );

    // Comparator model: rises when the ramp reaches the target; in glitch mode
    // it drops one step later and rises again, and idles high between phases.
    always_comb begin
        for (int i = 0; i < NC; i++) begin
            if (coarse_active)
                cmp[i] = (int'(coarse_code) >= tc[i]) && !(glitch && int'(coarse_code) == tc[i] + 1);
            else if (fine_active)
                cmp[i] = (int'(fine_code) >= tf[i]) && !(glitch && int'(fine_code) == tf[i] + 1);
            else
                cmp[i] = glitch;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_c(int i);
        return (tc[i] > 31) ? 31 : tc[i];
    endfunction

    function automatic int exp_f(int i);
        return (tf[i] > 127) ? 127 : tf[i];
    endfunction

    function automatic string tag_of(int i);
        if (tc[i] == 0 || tf[i] == 0) return "R11";
        if (tc[i] > 31 || tf[i] > 127) return "R7";
        if (glitch) return "R6";
        return "R5";
    endfunction

    task automatic run_conv(input int row, input int seed, input bit g, input bit poke);
        logic [4:0] flags_exp;
        logic [4:0] flags_act;
        int code_exp;
        int code_act;
        bit seen_done = 1'b0;
        glitch = g;
        row_addr = 6'(row);
        for (int i = 0; i < NC; i++) begin
            tc[i] = (i * seed + row) % 33;
            tf[i] = (i * seed * 3 + row + 7) % 129;
        end
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        chk(sample_en && busy, "R2 sample", sample_en, 1);
        chk(row_sel == (64'd1 << row), "R10 row select", row_sel, 64'd1 << row);
        for (int n = 1; n <= 170 && !seen_done; n++) begin
            @(posedge clk);
            #1;
            if (poke && n == 50) start = 1'b1;
            if (poke && n == 52) start = 1'b0;
            code_exp = 0;
            code_act = 0;
            if (n <= 32) begin
                flags_exp = 5'b01001; code_exp = n - 1; code_act = int'(coarse_code);
            end else if (n == 33) begin
                flags_exp = 5'b00001;
            end else if (n <= 161) begin
                flags_exp = 5'b00101; code_exp = n - 34; code_act = int'(fine_code);
            end else begin
                flags_exp = 5'b00011;
            end
            flags_act = {sample_en, coarse_active, fine_active, done, busy};
            chk(flags_act == flags_exp, poke ? "R4 phase under start" : "R2 phase", flags_act, flags_exp);
            chk(code_act == code_exp, "R2 ramp code", code_act, code_exp);
            if (n == 33) begin
                chk(row_sel == '0, "R10 row idle", row_sel, 0);
                for (int i = 0; i < NC; i++)
                    chk(int'(ref_sel[i*5 +: 5]) == exp_c(i), "R9 select at settle", ref_sel[i*5 +: 5], exp_c(i));
            end
            if (done) begin
                seen_done = 1'b1;
                chk(n == 162, "R2 done timing", n, 162);
                for (int i = 0; i < NC; i++)
                    chk(int'(ref_sel[i*5 +: 5]) == exp_c(i), "R9 select at done", ref_sel[i*5 +: 5], exp_c(i));
            end
        end
        chk(seen_done, "R2 done seen", seen_done, 1);
        @(posedge clk);
        #1;
        chk(!done && !busy, "R3 done one cycle", {done, busy}, 0);
        for (int c = 0; c < NC; c++) begin
            rd_col = 6'(c);
            #1;
            chk(int'(rd_data[11:7]) == exp_c(c), {"R8 coarse ", tag_of(c)}, rd_data[11:7], exp_c(c));
            chk(int'(rd_data[6:0]) == exp_f(c), {"R8 fine ", tag_of(c)}, rd_data[6:0], exp_f(c));
        end
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin
            tc[i] = 40;
            tf[i] = 200;
        end
        repeat (3) @(posedge clk);
        #1;
        chk({busy, done, sample_en, coarse_active, fine_active} == 5'b0, "R1 flags", {busy, done, sample_en, coarse_active, fine_active}, 0);
        chk(row_sel == '0, "R1 row select", row_sel, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c += 9) begin
            rd_col = 6'(c);
            #1;
            chk(rd_data == '0, "R1 readout", rd_data, 0);
        end
        run_conv(0, 1, 1'b0, 1'b0);
        run_conv(5, 7, 1'b1, 1'b0);
        run_conv(63, 11, 1'b0, 1'b1);
        run_conv(17, 13, 1'b1, 1'b0);
        run_conv(32, 5, 1'b0, 1'b0);
        run_conv(41, 3, 1'b1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule